// File: doc/BRIEF.md
# Two-Address Stored-Program Sequencer

This block is the control unit of a small stored-program machine. It keeps a program counter, an instruction register, a working register and the two memory interface registers (an address register and a data register). It runs the machine by walking through fetch, decode and execute for one instruction at a time. Every step is a single register transfer. Every memory access goes out as a request and then waits for the memory's completion strobe.

Each instruction occupies one memory cell. The cell holds an 8-bit operation code and two 16-bit address fields, called A and B. Data cells have the same width as instruction cells. Four operations are recognised: load, add, compare and halt. Add and compare work memory-to-memory on cells A and B. A three-flag condition register (greater, equal, less) keeps the result of the last compare.

The memory request channel is valid/ready. Once the block raises `mem_req_valid`, it holds the address, direction and write data unchanged until the cycle in which `mem_req_ready` is high. That cycle is the hand-off. After the hand-off the block raises no new request until it has seen `mem_rsp_done`. Read data is taken from `mem_rsp_data` in the done cycle. The done strobe must come at least one cycle after the hand-off, and it is also required for writes. The memory may hold `mem_req_ready` low for as long as it needs. While it does, the block simply waits.

Top module: `fde_ctrl`

## Requirements
- R1: After reset the program counter is 0, all three flags are 0, the working register is 0, `halted` and `bad_opcode` are 0, and the first request is a read of address 0.
- R2: An instruction cell holds the operation code in bits [39:32], field A in bits [31:16] and field B in bits [15:0]. The program counter advances by one per instruction.
- R3: Every instruction starts with a read at the program counter. The program counter is incremented after the fetched word is in the instruction register and before the operation is decoded.
- R4: Operation code 1 (load) reads cell A and puts its value in the working register.
- R5: Operation code 9 (add) reads cell A, then reads cell B, then writes the sum to cell B. The sum is taken modulo 2^40, so the carry is dropped. The working register is not changed.
- R6: Operation code 7 (compare) reads cell A and then cell B. It then sets exactly one flag, comparing the value of B against the value of A as unsigned numbers: greater when B > A, equal when B = A, less when B < A. The flags keep their values until the next compare.
- R7: Operation code 15 (halt) raises `halted`, which stays high until reset. While halted, no request is issued, `bad_opcode` stays 0, and the program counter points one past the halt instruction.
- R8: Any other operation code halts the block in the same way and raises `bad_opcode`.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted and its address, direction and write data do not change.
- R10: After a hand-off, no new request is raised before `mem_rsp_done` has been seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_valid | output | 1 | Memory request pending |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = store, 0 = fetch |
| mem_req_addr | output | 16 | Cell address (address register) |
| mem_req_wdata | output | 40 | Store data (data register) |
| mem_rsp_done | input | 1 | Access complete; read data valid |
| mem_rsp_data | input | 40 | Read data |
| halted | output | 1 | Controller stopped |
| bad_opcode | output | 1 | Stopped on an unknown operation code |
| pc_out | output | 16 | Program counter |
| work_out | output | 40 | Working register |
| cc_gt | output | 1 | Last compare: B greater than A |
| cc_eq | output | 1 | Last compare: B equal to A |
| cc_lt | output | 1 | Last compare: B less than A |

## Verification
The assertions check on every cycle the channel rules that hold no matter what program runs. These are request stability under back-pressure, no new request while one is outstanding, silence and permanence once halted, at most one flag set, the error flag only in the halted state, and a first fetch at address 0. Only the bench's programs can show the order and data of the accesses each operation makes, the wrapped add result written into memory, the compare direction and flag persistence, and the program counter value at the halt. The bench shows these by comparing every accepted request with a queue built by a behavioural interpreter of the same program.

// File: rtl/fde_pkg.sv
package fde_pkg;
  localparam int OPC_W  = 8;
  localparam int ADR_W  = 16;
  localparam int CELL_W = OPC_W + 2 * ADR_W;

  localparam int OPC_LOAD = 1;
  localparam int OPC_CMP  = 7;
  localparam int OPC_ADD  = 9;
  localparam int OPC_STOP = 15;

  typedef enum logic [1:0] {
    KIND_LOAD,
    KIND_CMP,
    KIND_ADD,
    KIND_STOP
  } op_kind_t;

  typedef enum logic [3:0] {
    ST_F_MAR,
    ST_F_IR,
    ST_F_INC,
    ST_DEC,
    ST_L_MAR,
    ST_L_WR,
    ST_O_MAR1,
    ST_O_SAVE,
    ST_O_MAR2,
    ST_O_EXEC,
    ST_MREQ,
    ST_MWAIT,
    ST_HALT
  } step_t;
endpackage

// File: rtl/fde_decoder.sv
module fde_decoder
  import fde_pkg::*;
#(
  parameter int OW = OPC_W
) (
  input  logic [OW-1:0] opcode,
  output op_kind_t      kind,
  output logic          illegal
);
  always_comb begin
    kind    = KIND_STOP;
    illegal = 1'b0;
    if (opcode == OW'(OPC_LOAD))      kind = KIND_LOAD;
    else if (opcode == OW'(OPC_CMP))  kind = KIND_CMP;
    else if (opcode == OW'(OPC_ADD))  kind = KIND_ADD;
    else if (opcode == OW'(OPC_STOP)) kind = KIND_STOP;
    else                              illegal = 1'b1;
  end
endmodule

// File: rtl/fde_ccr.sv
module fde_ccr #(
  parameter int W = fde_pkg::CELL_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic [W-1:0] first_val,
  input  logic [W-1:0] second_val,
  output logic         gt,
  output logic         eq,
  output logic         lt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gt <= 1'b0;
      eq <= 1'b0;
      lt <= 1'b0;
    end else if (upd) begin
      gt <= second_val > first_val;
      eq <= second_val == first_val;
      lt <= second_val < first_val;
    end
  end
endmodule

// File: rtl/fde_sequencer.sv
module fde_sequencer
  import fde_pkg::*;
#(
  parameter int OW = OPC_W,
  parameter int AW = ADR_W
) (
  input  logic                clk,
  input  logic                rst_n,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [AW-1:0]       mem_req_addr,
  output logic [OW+2*AW-1:0]  mem_req_wdata,
  input  logic                mem_rsp_done,
  input  logic [OW+2*AW-1:0]  mem_rsp_data,
  input  op_kind_t            kind,
  input  logic                illegal,
  output logic [OW-1:0]       opcode,
  output logic                cc_upd,
  output logic [OW+2*AW-1:0]  cmp_first,
  output logic [OW+2*AW-1:0]  cmp_second,
  output logic                halted,
  output logic                bad_opcode,
  output logic [AW-1:0]       pc,
  output logic [OW+2*AW-1:0]  work
);
  localparam int CW = OW + 2 * AW;

  step_t          step, ret_step;
  logic [CW-1:0]  ir, mdr, opnd;
  logic [AW-1:0]  mar;
  logic           wr_q;
  logic [AW-1:0]  fld_a, fld_b;

  assign fld_a  = ir[2*AW-1:AW];
  assign fld_b  = ir[AW-1:0];
  assign opcode = ir[CW-1:2*AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step       <= ST_F_MAR;
      ret_step   <= ST_F_MAR;
      pc         <= '0;
      ir         <= '0;
      mdr        <= '0;
      opnd       <= '0;
      mar        <= '0;
      wr_q       <= 1'b0;
      work       <= '0;
      bad_opcode <= 1'b0;
    end else begin
      case (step)
        ST_F_MAR: begin
          mar      <= pc;
          wr_q     <= 1'b0;
          ret_step <= ST_F_IR;
          step     <= ST_MREQ;
        end
        ST_MREQ: if (mem_req_ready) step <= ST_MWAIT;
        ST_MWAIT: if (mem_rsp_done) begin
          if (!wr_q) mdr <= mem_rsp_data;
          step <= ret_step;
        end
        ST_F_IR: begin
          ir   <= mdr;
          step <= ST_F_INC;
        end
        ST_F_INC: begin
          pc   <= pc + 1'b1;
          step <= ST_DEC;
        end
        ST_DEC: begin
          case (kind)
            KIND_LOAD: step <= ST_L_MAR;
            KIND_CMP,
            KIND_ADD:  step <= ST_O_MAR1;
            default: begin
              bad_opcode <= illegal;
              step       <= ST_HALT;
            end
          endcase
        end
        ST_L_MAR: begin
          mar      <= fld_a;
          wr_q     <= 1'b0;
          ret_step <= ST_L_WR;
          step     <= ST_MREQ;
        end
        ST_L_WR: begin
          work <= mdr;
          step <= ST_F_MAR;
        end
        ST_O_MAR1: begin
          mar      <= fld_a;
          wr_q     <= 1'b0;
          ret_step <= ST_O_SAVE;
          step     <= ST_MREQ;
        end
        ST_O_SAVE: begin
          opnd <= mdr;
          step <= ST_O_MAR2;
        end
        ST_O_MAR2: begin
          mar      <= fld_b;
          wr_q     <= 1'b0;
          ret_step <= ST_O_EXEC;
          step     <= ST_MREQ;
        end
        ST_O_EXEC: begin
          if (kind == KIND_ADD) begin
            mdr      <= opnd + mdr;
            wr_q     <= 1'b1;
            ret_step <= ST_F_MAR;
            step     <= ST_MREQ;
          end else begin
            step <= ST_F_MAR;
          end
        end
        default: step <= ST_HALT;
      endcase
    end
  end

  assign mem_req_valid = (step == ST_MREQ);
  assign mem_req_write = wr_q;
  assign mem_req_addr  = mar;
  assign mem_req_wdata = mdr;
  assign cc_upd        = (step == ST_O_EXEC) && (kind == KIND_CMP);
  assign cmp_first     = opnd;
  assign cmp_second    = mdr;
  assign halted        = (step == ST_HALT);
endmodule

// File: rtl/fde_ctrl.sv
module fde_ctrl
  import fde_pkg::*;
#(
  parameter int OW = OPC_W,
  parameter int AW = ADR_W
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [AW-1:0]      mem_req_addr,
  output logic [OW+2*AW-1:0] mem_req_wdata,
  input  logic               mem_rsp_done,
  input  logic [OW+2*AW-1:0] mem_rsp_data,
  output logic               halted,
  output logic               bad_opcode,
  output logic [AW-1:0]      pc_out,
  output logic [OW+2*AW-1:0] work_out,
  output logic               cc_gt,
  output logic               cc_eq,
  output logic               cc_lt
);
  localparam int CW = OW + 2 * AW;

  op_kind_t       kind;
  logic           illegal;
  logic [OW-1:0]  opcode;
  logic           cc_upd;
  logic [CW-1:0]  cmp_first, cmp_second;

  fde_decoder #(.OW(OW)) u_dec (
    .opcode  (opcode),
    .kind    (kind),
    .illegal (illegal)
  );

  fde_ccr #(.W(CW)) u_ccr (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd        (cc_upd),
    .first_val  (cmp_first),
    .second_val (cmp_second),
    .gt         (cc_gt),
    .eq         (cc_eq),
    .lt         (cc_lt)
  );

  fde_sequencer #(.OW(OW), .AW(AW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_write (mem_req_write),
    .mem_req_addr  (mem_req_addr),
    .mem_req_wdata (mem_req_wdata),
    .mem_rsp_done  (mem_rsp_done),
    .mem_rsp_data  (mem_rsp_data),
    .kind          (kind),
    .illegal       (illegal),
    .opcode        (opcode),
    .cc_upd        (cc_upd),
    .cmp_first     (cmp_first),
    .cmp_second    (cmp_second),
    .halted        (halted),
    .bad_opcode    (bad_opcode),
    .pc            (pc_out),
    .work          (work_out)
  );
endmodule

// File: rtl/fde_ctrl_chk.sv
module fde_ctrl_chk #(
  parameter int AW = 16,
  parameter int CW = 40
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_write,
  input logic [AW-1:0] mem_req_addr,
  input logic [CW-1:0] mem_req_wdata,
  input logic          mem_rsp_done,
  input logic          halted,
  input logic          bad_opcode,
  input logic          cc_gt,
  input logic          cc_eq,
  input logic          cc_lt
);
  logic outstanding;
  logic seen_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= 1'b0;
      seen_req    <= 1'b0;
    end else begin
      if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
      else if (mem_rsp_done)              outstanding <= 1'b0;
      if (mem_req_valid) seen_req <= 1'b1;
    end
  end

  assert_first_fetch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !seen_req) |-> (!mem_req_write && mem_req_addr == '0));

  assert_one_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({cc_gt, cc_eq, cc_lt}) <= 1);

  assert_quiet_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req_valid);

  assert_stay_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  assert_err_halt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bad_opcode |-> halted);

  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write) && $stable(mem_req_wdata)));

  assert_wait_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding |-> !mem_req_valid);
endmodule

bind fde_ctrl fde_ctrl_chk #(.AW(AW), .CW(OW + 2 * AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .mem_rsp_done  (mem_rsp_done),
  .halted        (halted),
  .bad_opcode    (bad_opcode),
  .cc_gt         (cc_gt),
  .cc_eq         (cc_eq),
  .cc_lt         (cc_lt)
);

// File: tb/fde_ctrl_tb.sv
`timescale 1ns/1ps
module fde_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [15:0] mem_req_addr;
  logic [39:0] mem_req_wdata;
  logic        mem_rsp_done = 1'b0;
  logic [39:0] mem_rsp_data = '0;
  logic        halted, bad_opcode, cc_gt, cc_eq, cc_lt;
  logic [15:0] pc_out;
  logic [39:0] work_out;

  always #2.5 clk = ~clk;

  fde_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_done(mem_rsp_done),
    .mem_rsp_data(mem_rsp_data), .halted(halted), .bad_opcode(bad_opcode),
    .pc_out(pc_out), .work_out(work_out),
    .cc_gt(cc_gt), .cc_eq(cc_eq), .cc_lt(cc_lt)
  );

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [39:0] data;
    string       tag;
  } tx_t;

  logic [39:0] mem [0:255];
  tx_t         expq[$];
  int          tests = 0;
  int          fails = 0;
  int          cyc = 0;
  int          spurious = 0;
  int          hold_bad = 0;
  int          early_req = 0;
  bit          responder_on = 1'b0;

  logic [15:0] exp_pc;
  logic [39:0] exp_work;
  bit          exp_gt, exp_eq, exp_lt, exp_bad;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] ins(input int op, input int a, input int b);
    return {8'(op), 16'(a), 16'(b)};
  endfunction

  // behavioural interpreter of the program in mem[]
  task automatic build_expect();
    logic [39:0] m [0:255];
    logic [15:0] pc;
    bit running;
    for (int i = 0; i < 256; i++) m[i] = mem[i];
    expq.delete();
    pc = 0; exp_work = 0; exp_gt = 0; exp_eq = 0; exp_lt = 0; exp_bad = 0;
    running = 1;
    for (int n = 0; n < 200 && running; n++) begin
      logic [39:0] w;
      int op, a, b;
      w  = m[pc[7:0]];
      expq.push_back('{0, pc, 40'd0, "R3"});
      pc = pc + 1;
      op = int'(w[39:32]); a = int'(w[31:16]); b = int'(w[15:0]);
      if (op == 1) begin
        expq.push_back('{0, 16'(a), 40'd0, "R4"});
        exp_work = m[a];
      end else if (op == 7) begin
        expq.push_back('{0, 16'(a), 40'd0, "R6"});
        expq.push_back('{0, 16'(b), 40'd0, "R6"});
        exp_gt = m[b] > m[a]; exp_eq = m[b] == m[a]; exp_lt = m[b] < m[a];
      end else if (op == 9) begin
        logic [39:0] s;
        s = m[a] + m[b];
        expq.push_back('{0, 16'(a), 40'd0, "R5"});
        expq.push_back('{0, 16'(b), 40'd0, "R5"});
        expq.push_back('{1, 16'(b), s, "R5"});
        m[b] = s;
      end else begin
        exp_bad = (op != 15);
        running = 0;
      end
    end
    exp_pc = pc;
  endtask

  // memory responder, acting on falling edges
  initial begin
    bit busy = 0;
    int dly = 0;
    logic [39:0] rd_val = '0;
    bit prev_stall = 0;
    logic [15:0] prev_addr = '0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_done = 1'b0;
      if (halted && mem_req_valid) spurious++;
      if (prev_stall && (!mem_req_valid || mem_req_addr != prev_addr)) hold_bad++;
      if (!responder_on) begin
        busy = 0; mem_req_ready = 1'b0; prev_stall = 0;
      end else if (busy) begin
        mem_req_ready = 1'b0;
        prev_stall = 0;
        if (mem_req_valid) early_req++;
        if (dly == 0) begin
          mem_rsp_done = 1'b1;
          mem_rsp_data = rd_val;
          busy = 0;
        end else dly--;
      end else begin
        mem_req_ready = (cyc % 3) != 2;
        prev_stall = mem_req_valid && !mem_req_ready;
        prev_addr  = mem_req_addr;
        if (mem_req_valid && mem_req_ready) begin
          if (expq.size() == 0) begin
            chk(0, "R3 extra request", 64'(mem_req_addr), 64'hFFFF);
          end else begin
            tx_t e;
            e = expq.pop_front();
            chk(mem_req_write == e.wr && mem_req_addr == e.addr, e.tag,
                {mem_req_write, 47'd0, mem_req_addr}, {e.wr, 47'd0, e.addr});
            if (e.wr) chk(mem_req_wdata == e.data, {e.tag, " store data"},
                          64'(mem_req_wdata), 64'(e.data));
          end
          if (mem_req_write) mem[mem_req_addr[7:0]] = mem_req_wdata;
          else rd_val = mem[mem_req_addr[7:0]];
          busy = 1;
          dly = cyc % 3;
        end
      end
    end
  end

  task automatic run_prog(input string name);
    int waited;
    build_expect();
    spurious = 0; hold_bad = 0; early_req = 0;
    responder_on = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(pc_out == 0 && !cc_gt && !cc_eq && !cc_lt && !halted && !bad_opcode && work_out == 0
        && !mem_req_valid, "R1 reset state", {pc_out, 5'd0, cc_gt, cc_eq, cc_lt, 8'd0}, 64'd0);
    responder_on = 1;
    rst_n = 1'b1;
    waited = 0;
    while (!halted && waited < 5000) begin
      @(negedge clk);
      waited++;
    end
    chk(halted, {"R7 halt reached ", name}, 64'(halted), 64'd1);
    repeat (6) @(negedge clk);
    chk(expq.size() == 0, {"R3 missing requests ", name}, 64'(expq.size()), 64'd0);
    chk(pc_out == exp_pc, {"R2 final pc ", name}, 64'(pc_out), 64'(exp_pc));
    chk(work_out == exp_work, {"R4 working register ", name}, 64'(work_out), 64'(exp_work));
    chk({cc_gt, cc_eq, cc_lt} == {exp_gt, exp_eq, exp_lt}, {"R6 flags ", name},
        64'({cc_gt, cc_eq, cc_lt}), 64'({exp_gt, exp_eq, exp_lt}));
    chk(bad_opcode == exp_bad, {"R8 error flag ", name}, 64'(bad_opcode), 64'(exp_bad));
    chk(spurious == 0 && halted, {"R7 silent while halted ", name}, 64'(spurious), 64'd0);
    chk(hold_bad == 0, {"R9 request held ", name}, 64'(hold_bad), 64'd0);
    chk(early_req == 0, {"R10 wait for done ", name}, 64'(early_req), 64'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    // program 1: load, add, compare greater, load result
    mem[0] = ins(1, 20, 0);
    mem[1] = ins(9, 20, 21);
    mem[2] = ins(7, 20, 21);
    mem[3] = ins(1, 21, 0);
    mem[4] = ins(15, 0, 0);
    mem[20] = 40'd5; mem[21] = 40'd7;
    run_prog("p1");
    chk(mem[21] == 40'd12, "R5 sum stored at B", 64'(mem[21]), 64'd12);
    chk(work_out == 40'd12 && cc_gt, "R6 B greater sets gt", 64'(work_out), 64'd12);

    // program 2: wrapping add, equal, less, then unknown opcode
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0] = ins(9, 30, 31);
    mem[1] = ins(7, 31, 31);
    mem[2] = ins(7, 30, 31);
    mem[3] = ins(8'h22, 1, 2);
    mem[30] = 40'hFF_FFFF_FFFF; mem[31] = 40'd2;
    run_prog("p2");
    chk(mem[31] == 40'd1, "R5 carry dropped", 64'(mem[31]), 64'd1);
    chk(cc_lt && !cc_gt && !cc_eq, "R6 B less sets lt", 64'({cc_gt, cc_eq, cc_lt}), 64'd1);
    chk(bad_opcode && pc_out == 16'd4, "R8 unknown opcode halts", 64'(pc_out), 64'd4);

    // program 3: immediate halt
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0] = ins(15, 7, 9);
    run_prog("p3");
    chk(pc_out == 16'd1 && !bad_opcode, "R7 pc past halt", 64'(pc_out), 64'd1);

    // program 4: compare equal persists across load and add
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[0] = ins(7, 40, 41);
    mem[1] = ins(1, 40, 0);
    mem[2] = ins(9, 40, 42);
    mem[3] = ins(15, 0, 0);
    mem[40] = 40'd3; mem[41] = 40'd3; mem[42] = 40'h80_0000_0000;
    run_prog("p4");
    chk(cc_eq && work_out == 40'd3, "R6 flags persist, R5 work unchanged", 64'(work_out), 64'd3);
    chk(mem[42] == 40'h80_0000_0003, "R5 sum high bit", 64'(mem[42]), 64'h80_0000_0003);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule